// File: doc/BRIEF.md
# Dual-Bridge Fixed-Frequency Current Chopper

This block is the digital control for two H-bridges that hold winding current by fixed-frequency chopping. One shared period counter sets the chopping frequency. It gives each bridge a period start, and bridge 1's start sits half a period after bridge 0's. That spread keeps the two source turn-on events apart in time.

At its own period start, a bridge switches on the source side of its winding. A blanking counter then masks the sense-trip comparator bit for a programmable number of cycles, so turn-on spikes cannot end the pulse early. After blanking, a trip clears the bridge's source latch. The winding then recirculates with both legs driven low (slow decay) until the bridge's next period start. Each bridge also has a coast input, which floats both legs so that current decays fast through the body diodes. A global wake input and a global fault input turn every output off.

Each leg output is registered. A leg never steps directly between high and low: when either leg of a bridge would reverse, both legs of that bridge spend one cycle off first.

Top module: `dual_chopper_ctrl`

## Requirements
- R1: While reset is asserted, every leg output reads off. The leg encoding is off = 2'b00, low = 2'b01, high = 2'b10.
- R2: When `wake` is low, all four leg outputs are off from the next cycle, and the period counter is held at zero.
- R3: While `fault` is high, all leg outputs are off from the next cycle. After `fault` clears, driving resumes under the normal rules.
- R4: When `wake` is high, `fault` is low and a bridge's `coast` bit is 1, both legs of that bridge are off from the next cycle. The other bridge is not affected.
- R5: With the source latch set, phase 1 drives leg A high and leg B low, and phase 0 drives leg A low and leg B high. Both legs of one bridge are never high together.
- R6: A trip taken after blanking clears the source latch. The bridge then drives both legs low until its next period start.
- R7: For `blank_len` cycles after each period start, the synchronized trip is ignored. With the trip held high all the time, leg A is high for exactly `blank_len` cycles in each period.
- R8: The period counter counts from 0 to `period_len`-1. Bridge 0 starts when the count is 0, and bridge 1 starts when the count is `period_len`/2 (rounded down).
- R9: A bridge takes its phase input only at its own period start. A change in mid-period leaves the drive unchanged until the next start.
- R10: No leg output ever changes from high to low, or from low to high, between two consecutive cycles. Instead, both legs of that bridge are off for one cycle.
- R11: Each trip bit passes through two synchronizer flops before it is used. A one-cycle trip pulse present before the edge at which the count reaches 10 turns leg A off at count 13, and leg A is still high at count 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wake | input | 1 | 1 = operate, 0 = sleep (all legs off, counter held) |
| fault | input | 1 | Combined fault / undervoltage flag; 1 forces all legs off |
| period_len | input | CNT_W | Chopping period in clock cycles |
| blank_len | input | CNT_W | Trip blanking length in cycles, below `period_len` |
| phase | input | 2 | Direction per bridge, bit g for bridge g |
| coast | input | 2 | 1 = float both legs of bridge g (fast decay) |
| sense_trip | input | 2 | Asynchronous current-trip comparator bit per bridge |
| drv_a0 | output | 2 | Bridge 0 leg A state |
| drv_b0 | output | 2 | Bridge 0 leg B state |
| drv_a1 | output | 2 | Bridge 1 leg A state |
| drv_b1 | output | 2 | Bridge 1 leg B state |

## Verification
The hardest situation to reach is a trip that lands at an exact offset inside one bridge's own period. Bridge 1's period is shifted by half a count, and the trip must also cross two synchronizer stages. The bench therefore drives `sense_trip` from its model's view of each bridge's position in its period. It uses four patterns: a held-high trip to measure blanking, a window after blanking, a single-cycle pulse at a known count, and no trip at all. It then samples the legs at precise counts to check blanking length, the start of slow decay and the synchronizer latency. An odd period, selected while asleep, checks that the half-period offset rounds down.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // Drive state of one bridge leg
  typedef enum logic [1:0] {
    LEG_OFF  = 2'b00,
    LEG_LOW  = 2'b01,
    LEG_HIGH = 2'b10
  } leg_t;

  localparam int NUM_BRIDGES = 2;
  localparam int SYNC_STAGES = 2;

  // True when a leg would switch straight between its two driven states
  function automatic logic leg_reverses(leg_t cur, leg_t want);
    return ((cur == LEG_HIGH) && (want == LEG_LOW)) ||
           ((cur == LEG_LOW)  && (want == LEG_HIGH));
  endfunction

endpackage

// File: rtl/chop_rst_sync.sv
module chop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_sync = stg_q[1];

endmodule

// File: rtl/chop_timebase.sv
module chop_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period_len,
  output logic [1:0]       start
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_pt, last_pt;
  logic             wrap;

  always_comb begin
    half_pt = period_len >> 1;
    last_pt = period_len - ONE;
    wrap    = (cnt_q >= last_pt);
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Bridge 0 starts at count zero, bridge 1 half a period later
  assign start[0] = run && (cnt_q == '0);
  assign start[1] = run && (cnt_q == half_pt);

endmodule

// File: rtl/chop_trip_sync.sv
module chop_trip_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/chop_bridge.sv
module chop_bridge
  import chop_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             awake,
  input  logic             fault,
  input  logic             start,
  input  logic [CNT_W-1:0] blank_len,
  input  logic             phase,
  input  logic             coast,
  input  logic             trip_s,
  output leg_t             leg_a,
  output leg_t             leg_b
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             src_q, src_d;
  logic [CNT_W-1:0] blk_q, blk_d;
  logic             ph_q, ph_d;
  logic             blanking;
  leg_t             want_a, want_b;
  leg_t             a_q, b_q, a_d, b_d;

  assign blanking = (blk_q != '0);

  // Source latch, blanking counter and period-held direction
  always_comb begin
    src_d = src_q;
    blk_d = blk_q;
    ph_d  = ph_q;
    if (!awake) begin
      src_d = 1'b0;
      blk_d = '0;
    end else if (start) begin
      src_d = 1'b1;
      blk_d = blank_len;
      ph_d  = phase;
    end else if (blanking) begin
      blk_d = blk_q - ONE;
    end else if (trip_s) begin
      src_d = 1'b0;
    end
  end

  // Wanted leg states, then one off cycle on any leg reversal
  always_comb begin
    if (!awake || fault || coast) begin
      want_a = LEG_OFF;
      want_b = LEG_OFF;
    end else if (!src_q) begin
      want_a = LEG_LOW;
      want_b = LEG_LOW;
    end else if (ph_q) begin
      want_a = LEG_HIGH;
      want_b = LEG_LOW;
    end else begin
      want_a = LEG_LOW;
      want_b = LEG_HIGH;
    end

    if (leg_reverses(a_q, want_a) || leg_reverses(b_q, want_b)) begin
      a_d = LEG_OFF;
      b_d = LEG_OFF;
    end else begin
      a_d = want_a;
      b_d = want_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      blk_q <= '0;
      ph_q  <= 1'b0;
      a_q   <= LEG_OFF;
      b_q   <= LEG_OFF;
    end else begin
      src_q <= src_d;
      blk_q <= blk_d;
      ph_q  <= ph_d;
      a_q   <= a_d;
      b_q   <= b_d;
    end
  end

  assign leg_a = a_q;
  assign leg_b = b_q;

endmodule

// File: rtl/dual_chopper_ctrl.sv
module dual_chopper_ctrl
  import chop_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake,
  input  logic             fault,
  input  logic [CNT_W-1:0] period_len,
  input  logic [CNT_W-1:0] blank_len,
  input  logic [1:0]       phase,
  input  logic [1:0]       coast,
  input  logic [1:0]       sense_trip,
  output logic [1:0]       drv_a0,
  output logic [1:0]       drv_b0,
  output logic [1:0]       drv_a1,
  output logic [1:0]       drv_b1
);

  logic                   rst_int_n;
  logic [NUM_BRIDGES-1:0] start;
  logic [NUM_BRIDGES-1:0] trip_s;
  leg_t                   leg_a [NUM_BRIDGES];
  leg_t                   leg_b [NUM_BRIDGES];

  chop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  chop_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (wake),
    .period_len (period_len),
    .start      (start)
  );

  chop_trip_sync #(.WIDTH(NUM_BRIDGES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (sense_trip),
    .dout  (trip_s)
  );

  for (genvar g = 0; g < NUM_BRIDGES; g++) begin : g_br
    chop_bridge #(.CNT_W(CNT_W)) u_br (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .awake     (wake),
      .fault     (fault),
      .start     (start[g]),
      .blank_len (blank_len),
      .phase     (phase[g]),
      .coast     (coast[g]),
      .trip_s    (trip_s[g]),
      .leg_a     (leg_a[g]),
      .leg_b     (leg_b[g])
    );
  end

  assign drv_a0 = leg_a[0];
  assign drv_b0 = leg_b[0];
  assign drv_a1 = leg_a[1];
  assign drv_b1 = leg_b[1];

endmodule

// File: rtl/chop_chk.sv
module chop_chk
  import chop_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wake,
  input logic       fault,
  input logic [1:0] coast,
  input logic [1:0] drv_a0,
  input logic [1:0] drv_b0,
  input logic [1:0] drv_a1,
  input logic [1:0] drv_b1
);

  logic [1:0] legs [4];
  assign legs[0] = drv_a0;
  assign legs[1] = drv_b0;
  assign legs[2] = drv_a1;
  assign legs[3] = drv_b1;

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_off_chk: assert ((drv_a0 == LEG_OFF) && (drv_b0 == LEG_OFF) &&
                             (drv_a1 == LEG_OFF) && (drv_b1 == LEG_OFF));
    end
  end

  // R2
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |=> ((drv_a0 == LEG_OFF) && (drv_b0 == LEG_OFF) &&
               (drv_a1 == LEG_OFF) && (drv_b1 == LEG_OFF)));

  // R3
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ((drv_a0 == LEG_OFF) && (drv_b0 == LEG_OFF) &&
               (drv_a1 == LEG_OFF) && (drv_b1 == LEG_OFF)));

  // R4
  coast0_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !fault && coast[0]) |=> ((drv_a0 == LEG_OFF) && (drv_b0 == LEG_OFF)));

  // R4
  coast1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !fault && coast[1]) |=> ((drv_a1 == LEG_OFF) && (drv_b1 == LEG_OFF)));

  // R5
  no_double_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((drv_a0 == LEG_HIGH) && (drv_b0 == LEG_HIGH)) &&
    !((drv_a1 == LEG_HIGH) && (drv_b1 == LEG_HIGH)));

  for (genvar k = 0; k < 4; k++) begin : g_leg
    // R10
    high_to_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (legs[k] == LEG_HIGH) |=> (legs[k] != LEG_LOW));
    // R10
    low_to_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (legs[k] == LEG_LOW) |=> (legs[k] != LEG_HIGH));
  end

endmodule

bind dual_chopper_ctrl chop_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wake   (wake),
  .fault  (fault),
  .coast  (coast),
  .drv_a0 (drv_a0),
  .drv_b0 (drv_b0),
  .drv_a1 (drv_a1),
  .drv_b1 (drv_b1)
);

// File: tb/sim_dual_chopper_ctrl.sv
`timescale 1ns/1ps
module sim_dual_chopper_ctrl;

  localparam logic [1:0] S_OFF  = 2'b00;
  localparam logic [1:0] S_LOW  = 2'b01;
  localparam logic [1:0] S_HIGH = 2'b10;
  localparam int BLANK = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wake, fault;
  logic [15:0] period_len, blank_len;
  logic [1:0]  phase, coast, sense_trip;
  logic [1:0]  drv_a0, drv_b0, drv_a1, drv_b1;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit cmp_on = 0;
  string tag = "R1";
  int tmode = 0;
  int flips = 0;
  int hi_cnt = 0;
  bit hi_en = 0;
  bit rose0, rose1;
  logic [1:0] prev_l [4];

  // reference model state
  int         mcnt;
  bit         msrc [2];
  int         mblk [2];
  bit         mph  [2];
  bit         ms1  [2];
  bit         ms2  [2];
  logic [1:0] ma   [2];
  logic [1:0] mb   [2];
  bit         r1, r2;

  always #2.5 clk = ~clk;

  dual_chopper_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wake(wake), .fault(fault),
    .period_len(period_len), .blank_len(blank_len),
    .phase(phase), .coast(coast), .sense_trip(sense_trip),
    .drv_a0(drv_a0), .drv_b0(drv_b0), .drv_a1(drv_a1), .drv_b1(drv_b1)
  );

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic bit rev(logic [1:0] c, logic [1:0] w);
    return (c == S_HIGH && w == S_LOW) || (c == S_LOW && w == S_HIGH);
  endfunction

  task automatic mclear();
    mcnt = 0;
    for (int b = 0; b < 2; b++) begin
      msrc[b] = 0; mblk[b] = 0; mph[b] = 0; ms1[b] = 0; ms2[b] = 0;
      ma[b] = S_OFF; mb[b] = S_OFF;
    end
  endtask

  task automatic mstep();
    int p = int'(period_len);
    int h = p / 2;
    bit st [2];
    logic [1:0] wa, wb;
    bit old2;
    for (int b = 0; b < 2; b++) begin
      if (!wake || fault || coast[b]) begin wa = S_OFF; wb = S_OFF; end
      else if (!msrc[b]) begin wa = S_LOW; wb = S_LOW; end
      else if (mph[b]) begin wa = S_HIGH; wb = S_LOW; end
      else begin wa = S_LOW; wb = S_HIGH; end
      if (rev(ma[b], wa) || rev(mb[b], wb)) begin ma[b] = S_OFF; mb[b] = S_OFF; end
      else begin ma[b] = wa; mb[b] = wb; end
    end
    st[0] = wake && (mcnt == 0);
    st[1] = wake && (mcnt == h);
    for (int b = 0; b < 2; b++) begin
      old2 = ms2[b];
      ms2[b] = ms1[b];
      ms1[b] = sense_trip[b];
      if (!wake) begin msrc[b] = 0; mblk[b] = 0; end
      else if (st[b]) begin msrc[b] = 1; mblk[b] = int'(blank_len); mph[b] = phase[b]; end
      else if (mblk[b] > 0) mblk[b]--;
      else if (old2) msrc[b] = 0;
    end
    if (!wake) mcnt = 0;
    else if (mcnt >= p - 1) mcnt = 0;
    else mcnt++;
  endtask

  initial begin
    mclear();
    r1 = 0; r2 = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      r1 = 0; r2 = 0;
      mclear();
    end else begin
      if (r2) mstep();
      r2 = r1;
      r1 = 1;
    end
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(tag, "bridge0 A", drv_a0, ma[0]);
      chk(tag, "bridge0 B", drv_b0, mb[0]);
      chk(tag, "bridge1 A", drv_a1, ma[1]);
      chk(tag, "bridge1 B", drv_b1, mb[1]);
    end
  end

  task automatic cyc(int n);
    int p, h, pos0, pos1;
    logic [1:0] cur [4];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      p = int'(period_len);
      h = p / 2;
      pos0 = mcnt;
      pos1 = (mcnt - h + p) % p;
      case (tmode)
        1: sense_trip = 2'b11;
        2: sense_trip = {(pos1 >= 8 && pos1 <= 11), (pos0 >= 8 && pos0 <= 11)};
        3: sense_trip = {(pos1 == 9), (pos0 == 9)};
        default: sense_trip = 2'b00;
      endcase
      cur[0] = drv_a0; cur[1] = drv_b0; cur[2] = drv_a1; cur[3] = drv_b1;
      for (int k = 0; k < 4; k++) begin
        if (rev(prev_l[k], cur[k])) flips++;
      end
      rose0 = (cur[0] == S_HIGH) && (prev_l[0] != S_HIGH);
      rose1 = (cur[2] == S_HIGH) && (prev_l[2] != S_HIGH);
      if (hi_en && cur[0] == S_HIGH) hi_cnt++;
      for (int k = 0; k < 4; k++) prev_l[k] = cur[k];
    end
  endtask

  task automatic wait_cnt(int v);
    cyc(1);
    while (mcnt != v) cyc(1);
  endtask

  task automatic rise_gap(int expd, string rq);
    int t;
    cyc(1);
    while (!rose0) cyc(1);
    t = 0;
    cyc(1); t++;
    while (!rose1) begin cyc(1); t++; end
    chk(rq, "bridge1 start offset", t, expd);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) prev_l[k] = S_OFF;
    rst_n = 1'b0; wake = 1'b1; fault = 1'b0;
    period_len = 16'd20; blank_len = 16'(BLANK);
    phase = 2'b01; coast = 2'b00; sense_trip = 2'b00;
    tag = "R1";
    cyc(3);
    chk("R1", "all legs in reset", {drv_a0, drv_b0, drv_a1, drv_b1}, 8'h00);
    rst_n = 1'b1;
    cmp_on = 1;

    tag = "R5";
    cyc(60);
    chk("R5", "bridge0 A phase1", drv_a0, S_HIGH);
    chk("R5", "bridge0 B phase1", drv_b0, S_LOW);
    chk("R5", "bridge1 A phase0", drv_a1, S_LOW);
    chk("R5", "bridge1 B phase0", drv_b1, S_HIGH);

    tag = "R6"; tmode = 2;
    cyc(40);
    wait_cnt(18);
    chk("R6", "bridge0 A slow decay", drv_a0, S_LOW);
    chk("R6", "bridge0 B slow decay", drv_b0, S_LOW);

    tag = "R7"; phase = 2'b11; tmode = 1;
    cyc(40);
    hi_cnt = 0; hi_en = 1;
    cyc(20);
    hi_en = 0;
    chk("R7", "A high cycles per period", hi_cnt, BLANK);

    tag = "R8";
    rise_gap(10, "R8");

    tag = "R2"; wake = 1'b0;
    cyc(3);
    chk("R2", "asleep legs", {drv_a0, drv_b0, drv_a1, drv_b1}, 8'h00);
    chk("R2", "model count held", mcnt, 0);
    period_len = 16'd21;
    cyc(2);
    wake = 1'b1;
    tag = "R8";
    cyc(63);
    rise_gap(10, "R8");

    tag = "R11"; tmode = 3;
    cyc(42);
    wait_cnt(12);
    chk("R11", "A still high at count 12", drv_a0, S_HIGH);
    cyc(1);
    chk("R11", "A off at count 13", drv_a0, S_OFF);
    cyc(1);
    chk("R11", "A low at count 14", drv_a0, S_LOW);

    tag = "R9"; tmode = 0;
    cyc(42);
    wait_cnt(3);
    phase = 2'b10;
    cyc(5);
    chk("R9", "A unchanged mid-period", drv_a0, S_HIGH);
    wait_cnt(5);
    chk("R9", "A after next start", drv_a0, S_LOW);
    chk("R9", "B after next start", drv_b0, S_HIGH);

    tag = "R4"; phase = 2'b01; coast = 2'b01;
    cyc(25);
    chk("R4", "coast bridge0 legs", {drv_a0, drv_b0}, 4'h0);
    chk("R4", "bridge1 unaffected A", drv_a1, S_LOW);
    chk("R4", "bridge1 unaffected B", drv_b1, S_HIGH);
    coast = 2'b00;

    tag = "R3"; fault = 1'b1;
    cyc(3);
    chk("R3", "fault legs", {drv_a0, drv_b0, drv_a1, drv_b1}, 8'h00);
    fault = 1'b0;
    cyc(42);
    chk("R3", "resume bridge0 A", drv_a0, S_HIGH);
    chk("R3", "resume bridge0 B", drv_b0, S_LOW);

    chk("R10", "direct high/low reversals", flips, 0);

    cmp_on = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule